// File: doc/BRIEF.md
# Walsh Spectrum Essential-Component Analyzer

The block collects a serial bit-stream of fixed length N and turns it into its Walsh spectrum. Each accepted bit becomes a signed sample, +1 for a logic 1 and -1 for a logic 0. The block then correlates the sample vector with every row of a Sylvester-ordered Hadamard matrix. An in-place fast transform over an internal coefficient store does this work, one add/subtract pair per clock.

After the transform, a readout port shows each coefficient together with a flag. The flag separates essential components from noise. A coefficient counts as essential when its normalized power c_k^2 / N^2 is above 1/N, the mean power a random stream puts into each coefficient. In integer terms this test is c_k^2 > N. A single-cycle done pulse marks the point where the whole spectrum can be read. A stimulus generator can use the essential components as the part of a stream to keep, and the rest as room for perturbation.

Top module: `walsh_spectrum_analyzer`

## Requirements
- R1: While reset is asserted and after it is released, every readable coefficient is 0, its essential flag is 0, and done is low.
- R2: After a start, the block accepts a bit only on clock edges where bit_valid is high. The first accepted bit is sample index 0. A 1 maps to +1 and a 0 maps to -1. Edges with bit_valid low change nothing.
- R3: When the transform finishes, coefficient k equals the sum over i of s_i * (-1)^popcount(i AND k), which is natural Hadamard row order. Row 1 alternates sign, starting with + at index 0.
- R4: rd_essential is 1 exactly when rd_coef squared is greater than N. This is the same as normalized power above 1/N.
- R5: An all-ones stream gives coefficient 0 equal to +N and every other coefficient equal to 0. Only index 0 is flagged essential.
- R6: done is high for exactly one cycle. It rises N/2*log2(N) clock edges after the edge that accepts the N-th bit.
- R7: A start that arrives while the block is collecting or transforming has no effect. Bits offered while the block is idle are ignored, so the stored spectrum stays unchanged.
- R8: No intermediate or final coefficient ever leaves the range -N..+N. The stored words are log2(N)+2 bits wide and signed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins collection of a new stream while the block is idle |
| bit_in | input | 1 | Serial stream bit |
| bit_valid | input | 1 | Qualifies bit_in |
| done | output | 1 | One-cycle pulse when the spectrum is complete |
| rd_idx | input | log2(N) | Coefficient index to read |
| rd_coef | output | log2(N)+2 | Signed coefficient at rd_idx |
| rd_essential | output | 1 | 1 when the coefficient at rd_idx is essential |

## Verification
The assertions assume two things about the inputs. The environment never needs start to restart a stream that is in progress. rd_idx is only meaningful after done, because the store holds partial sums during the transform. The bench raises start only while the block is idle, except in cases that deliberately press it while the block is busy to show that it is ignored. It drops bit_valid for single cycles with the opposite bit on bit_in. It reads coefficients only after it has seen the done pulse, and it drives every input half a period away from the active edge.

// File: rtl/walsh_pkg.sv
package walsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_XFORM = 2'd2
  } wst_t;
endpackage

// File: rtl/walsh_pair_seq.sv
module walsh_pair_seq #(
  parameter int LOG2N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [LOG2N-1:0] idx_lo,
  output logic [LOG2N-1:0] idx_hi,
  output logic             last
);
  localparam int SW = (LOG2N > 1) ? $clog2(LOG2N) : 1;
  localparam int PW = LOG2N - 1;
  localparam logic [SW-1:0] STAGE_MAX = SW'(LOG2N - 1);
  localparam logic [PW-1:0] PAIR_MAX  = '1;

  logic [SW-1:0]    stage_q, stage_d;
  logic [PW-1:0]    pair_q, pair_d;
  logic [LOG2N-1:0] pext, span, lowmask;

  // index pair: insert a zero at bit 'stage' of the pair count
  always_comb begin
    pext    = LOG2N'(pair_q);
    span    = LOG2N'(1) << stage_q;
    lowmask = span - LOG2N'(1);
    idx_lo  = ((pext & ~lowmask) << 1) | (pext & lowmask);
    idx_hi  = idx_lo | span;
    last    = (stage_q == STAGE_MAX) && (pair_q == PAIR_MAX);
  end

  always_comb begin
    stage_d = stage_q;
    pair_d  = pair_q;
    if (clear) begin
      stage_d = '0;
      pair_d  = '0;
    end else if (step) begin
      pair_d = pair_q + 1'b1;
      if (pair_q == PAIR_MAX) begin
        stage_d = (stage_q == STAGE_MAX) ? '0 : stage_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pair_q  <= '0;
    end else if (clear || step) begin
      stage_q <= stage_d;
      pair_q  <= pair_d;
    end
  end

  // R3: the lower index of a pair never has the stage bit set
  a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (idx_lo[stage_q] == 1'b0) && (idx_hi > idx_lo));

  // R3: stage counter stays within log2(N) passes
  a_r3_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q <= STAGE_MAX);
endmodule

// File: rtl/walsh_bfly.sv
module walsh_bfly #(
  parameter int W = 9
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] sum,
  output logic signed [W-1:0] diff
);
  always_comb begin
    sum  = a + b;
    diff = a - b;
  end
endmodule

// File: rtl/walsh_power_flag.sv
module walsh_power_flag #(
  parameter int N = 128,
  parameter int W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] coef,
  output logic                essential
);
  localparam int PW2 = 2 * W;
  localparam logic signed [PW2-1:0] THRESH = PW2'(N);
  localparam logic signed [W-1:0]   FULL   = W'(N);

  logic signed [PW2-1:0] cext, power;

  // integer form of c^2/N^2 > 1/N
  always_comb begin
    cext      = PW2'(coef);
    power     = cext * cext;
    essential = power > THRESH;
  end

  // R4: a zero coefficient carries no power
  a_r4_zero_is_noise: assert property (@(posedge clk) disable iff (!rst_n)
    (coef == '0) |-> !essential);

  // R4: a full-scale coefficient is always essential
  a_r4_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    ((coef == FULL) || (coef == -FULL)) |-> essential);
endmodule

// File: rtl/walsh_spectrum_analyzer.sv
module walsh_spectrum_analyzer
  import walsh_pkg::*;
#(
  parameter  int N     = 128,
  localparam int LOG2N = $clog2(N),
  localparam int W     = LOG2N + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                bit_in,
  input  logic                bit_valid,
  output logic                done,
  input  logic [LOG2N-1:0]    rd_idx,
  output logic signed [W-1:0] rd_coef,
  output logic                rd_essential
);
  localparam logic [LOG2N-1:0] CNT_LAST = '1;
  localparam logic signed [W-1:0] FULL  = W'(N);
  localparam logic signed [W-1:0] PLUS1 = W'(1);
  localparam logic signed [W-1:0] MINUS1 = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  wst_t             state_q, state_d;
  logic [LOG2N-1:0] load_cnt_q, load_cnt_d;
  logic             done_q, done_d;
  logic             ld_en, bf_en, seq_clear, seq_last;
  logic [LOG2N-1:0] idx_lo, idx_hi;
  logic signed [W-1:0] ld_word, bf_sum, bf_diff;
  logic signed [W-1:0] coef_q [N];

  walsh_pair_seq #(.LOG2N(LOG2N)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clear  (seq_clear),
    .step   (bf_en),
    .idx_lo (idx_lo),
    .idx_hi (idx_hi),
    .last   (seq_last)
  );

  walsh_bfly #(.W(W)) u_bfly (
    .a    (coef_q[idx_lo]),
    .b    (coef_q[idx_hi]),
    .sum  (bf_sum),
    .diff (bf_diff)
  );

  walsh_power_flag #(.N(N), .W(W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .coef      (rd_coef),
    .essential (rd_essential)
  );

  always_comb begin
    ld_word = bit_in ? PLUS1 : MINUS1;
    rd_coef = coef_q[rd_idx];
    done    = done_q;
  end

  // next-state logic
  always_comb begin
    state_d    = state_q;
    load_cnt_d = load_cnt_q;
    done_d     = 1'b0;
    ld_en      = 1'b0;
    bf_en      = 1'b0;
    seq_clear  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d    = ST_LOAD;
          load_cnt_d = '0;
        end
      end
      ST_LOAD: begin
        if (bit_valid) begin
          ld_en      = 1'b1;
          load_cnt_d = load_cnt_q + 1'b1;
          if (load_cnt_q == CNT_LAST) begin
            state_d   = ST_XFORM;
            seq_clear = 1'b1;
          end
        end
      end
      ST_XFORM: begin
        bf_en = 1'b1;
        if (seq_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      load_cnt_q <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (ld_en || (state_q == ST_IDLE)) load_cnt_q <= load_cnt_d;
    end
  end

  // coefficient store, written by the loader or by one butterfly per cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < N; i++) coef_q[i] <= '0;
    end else begin
      if (ld_en) coef_q[load_cnt_q] <= ld_word;
      if (bf_en) begin
        coef_q[idx_lo] <= bf_sum;
        coef_q[idx_hi] <= bf_diff;
      end
    end
  end

  // R8: butterfly results stay within -N..+N
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bf_en |-> (bf_sum <= FULL) && (bf_sum >= -FULL) &&
              (bf_diff <= FULL) && (bf_diff >= -FULL));

  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R6: done only follows the transform phase
  a_r6_done_after_xform: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(done) |-> $past(state_q) == ST_XFORM);

  // R7: an unfinished transform is not interrupted by start
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_XFORM && !seq_last) |=> state_q == ST_XFORM);

  // R2: without bit_valid the loader neither advances nor leaves
  a_r2_hold_no_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_LOAD && !bit_valid) |=> $stable(load_cnt_q) && state_q == ST_LOAD);
endmodule

// File: tb/test_walsh_spectrum_analyzer.sv
module test_walsh_spectrum_analyzer;
  localparam int CLK_P = 10;
  localparam int N     = 128;
  localparam int LOG2N = 7;
  localparam int W     = 9;
  localparam int XCYC  = N / 2 * LOG2N;
  localparam int NPAT  = 7;

  // stimulus table: stream, gaps in bit_valid, start pressed while busy
  localparam logic [N-1:0] PATS [NPAT] = '{
    {N{1'b1}},
    {N{1'b0}},
    128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA_AAAA,
    128'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F,
    128'h3C5A_96E1_7B02_D4F8_A1C3_5E69_0B7D_82F4,
    128'hFFFF_0000_FF00_00FF_F0F0_0F0F_CCCC_3333,
    128'h0000_0000_0000_0000_0000_0000_0000_0002
  };
  localparam logic [NPAT-1:0] GAPS = 7'b0101010;
  localparam logic [NPAT-1:0] POKE = 7'b0011100;

  logic clk = 1'b0;
  logic rst_n, start, bit_in, bit_valid;
  logic done, rd_essential;
  logic [LOG2N-1:0] rd_idx;
  logic signed [W-1:0] rd_coef;

  int nerr = 0;
  int nchk = 0;

  always #(CLK_P / 2) clk = ~clk;

  walsh_spectrum_analyzer #(.N(N)) i_walsh_spectrum_analyzer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .bit_in       (bit_in),
    .bit_valid    (bit_valid),
    .done         (done),
    .rd_idx       (rd_idx),
    .rd_coef      (rd_coef),
    .rd_essential (rd_essential)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_coef(input logic [N-1:0] p, input int k);
    int acc = 0;
    for (int i = 0; i < N; i++) begin
      int s = p[i] ? 1 : -1;
      if ($countones(i & k) % 2 == 1) s = -s;
      acc += s;
    end
    return acc;
  endfunction

  task automatic read_at(input int k, output int c, output bit e);
    @(negedge clk);
    rd_idx = LOG2N'(k);
    #1;
    c = int'(rd_coef);
    e = rd_essential;
  endtask

  task automatic run_stream(input logic [N-1:0] p, input bit gaps, input bit poke);
    int cyc = 0;
    int bad_c = -1, bad_f = -1, ac = 0, ec = 0;
    bit fa = 0, fe = 0;
    // R7: bits offered while idle must be ignored
    @(negedge clk);
    bit_valid = 1'b1;
    bit_in    = 1'b1;
    repeat (3) @(negedge clk);
    bit_valid = 1'b0;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (gaps && (i % 5 == 2)) begin
        bit_valid = 1'b0;
        bit_in    = ~p[i];
        @(negedge clk);
      end
      bit_valid = 1'b1;
      bit_in    = p[i];
      start     = (poke && i == 10);
      @(negedge clk);
      start = 1'b0;
    end
    bit_valid = 1'b0;
    while (cyc < 4 * XCYC) begin
      @(posedge clk);
      #1;
      cyc++;
      start     = poke && (cyc >= 5) && (cyc < 9);
      bit_valid = start;
      bit_in    = start;
      if (done) break;
    end
    start     = 1'b0;
    bit_valid = 1'b0;
    chk(cyc == XCYC, "R6", "cycles from last bit to done", cyc, XCYC);
    @(posedge clk);
    #1;
    chk(done == 1'b0, "R6", "done width", int'(done), 0);
    for (int k = 0; k < N; k++) begin
      int c, x;
      bit e;
      read_at(k, c, e);
      x = ref_coef(p, k);
      if (c != x && bad_c < 0) begin bad_c = k; ac = c; ec = x; end
      if (e != (x * x > N) && bad_f < 0) begin bad_f = k; fa = e; fe = (x * x > N); end
    end
    chk(bad_c < 0, "R3", $sformatf("coef at index %0d", bad_c), ac, ec);
    chk(bad_f < 0, "R4", $sformatf("flag at index %0d", bad_f), int'(fa), int'(fe));
  endtask

  initial begin
    rst_n     = 1'b0;
    start     = 1'b0;
    bit_in    = 1'b0;
    bit_valid = 1'b0;
    rd_idx    = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    begin
      int c;
      bit e;
      read_at(77, c, e);
      chk(c == 0 && !e, "R1", "coef 77 in reset", c, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    begin
      int c;
      bit e;
      read_at(0, c, e);
      chk(c == 0 && !e, "R1", "coef 0 after reset", c, 0);
    end

    for (int t = 0; t < NPAT; t++) begin
      run_stream(PATS[t], GAPS[t], POKE[t]);
      if (t == 0) begin
        // R5: all-ones stream, explicit points
        int c;
        bit e;
        read_at(0, c, e);
        chk(c == N, "R5", "c0 for all ones", c, N);
        chk(e == 1'b1, "R5", "flag 0 for all ones", int'(e), 1);
        read_at(1, c, e);
        chk(c == 0 && !e, "R5", "c1 for all ones", c, 0);
        read_at(N - 1, c, e);
        chk(c == 0 && !e, "R5", "c127 for all ones", c, 0);
      end
      if (t == NPAT - 1) begin
        // R2: only sample index 1 is high, so c1 = -2 and c0 = -126
        int c;
        bit e;
        read_at(0, c, e);
        chk(c == -126, "R2", "c0 with sample 1 high", c, -126);
        read_at(1, c, e);
        chk(c == -2, "R2", "c1 with sample 1 high", c, -2);
      end
    end

    // R7: idle bits without start leave the spectrum unchanged
    begin
      int c;
      bit e;
      @(negedge clk);
      bit_valid = 1'b1;
      for (int i = 0; i < 20; i++) begin
        bit_in = i[0];
        @(negedge clk);
      end
      bit_valid = 1'b0;
      repeat (3) @(negedge clk);
      read_at(0, c, e);
      chk(c == -126, "R7", "c0 after idle bits", c, -126);
      chk(done == 1'b0, "R7", "no done from idle bits", int'(done), 0);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule